// File: doc/BRIEF.md
# DDR Read-Data Resynchronization Stage

This block takes read words, together with their valid flag, from the strobe-domain capture registers and hands them to logic running on the system clock. The sampling instant is programmable. A cycle index picks how many system-clock periods to wait. A two-bit phase code then picks one of four quarter-period sampling edges within that period. Those edges come from the rising and falling edges of the system clock `clk`, and from a second clock `wr_clk` that has the same frequency and leads `clk` by a quarter period.

Once a word has been sampled on the chosen edge, it is moved onto the rising edge of `clk` and delayed by the chosen number of cycles. It can optionally pass through an intermediate register that relaxes the path into system-clock logic. It is then registered once more at the output. The CAS-latency code moves the programmed setting automatically, so the same cycle and phase values can be kept across memory speed grades.

Top module: `ddr_rsync_top`

## Requirements
- R1: While `rst_n` is low, `rd_valid` and `rd_data` are 0.
- R2: With phase code 0, the word is taken on the rising edge of `clk`. With CAS code 00, cycle 0 and the intermediate register off, a word presented during period i appears on the outputs after rising edge i+2.
- R3: Phase codes 1, 2 and 3 sample on three edges: the falling edge of `wr_clk` (quarter point), the falling edge of `clk` (half point) and the rising edge of `wr_clk` (three-quarter point). A word that settles after the selected edge in its period is taken one period later.
- R4: Each step of the cycle setting adds one `clk` period of latency, from 0 to 6. A setting of 7 acts as 6.
- R5: CAS code 01 adds two quarter-phases to the programmed phase. When the sum passes phase 3, it wraps modulo 4 and the effective cycle increases by one.
- R6: CAS code 10 adds one to the effective cycle. CAS code 11 behaves like code 00.
- R7: When `mid_reg_en` is 1, one extra `clk` period of latency is added.
- R8: `rd_valid` stays aligned with `rd_data` for every setting. `rd_data` is 0 whenever `rd_valid` is 0.
- R9: Total latency, counted in rising edges of `clk`, is: (1 for the sampling edge, or 2 if the word misses the selected edge) + effective cycle + intermediate register + 1 output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every output changes on its rising edge |
| wr_clk | input | 1 | Same-rate clock leading `clk` by a quarter period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_data | input | DW | Read word from the capture registers |
| cap_valid | input | 1 | Valid flag for `cap_data` |
| cyc_set | input | CW | Programmed resynchronization cycle (0..6, 7 clamps to 6) |
| phase_set | input | 2 | Phase code: 0 = clk rise, 1 = wr_clk fall, 2 = clk fall, 3 = wr_clk rise |
| cl_code | input | 2 | CAS code: 00 CL2, 01 CL2.5, 10 CL3, 11 as CL2 |
| mid_reg_en | input | 1 | Inserts the intermediate register |
| rd_data | output | DW | Resynchronized read word |
| rd_valid | output | 1 | Valid flag aligned with `rd_data` |

## Verification
The bench builds the block with its defaults: an 8-bit word and a cycle limit of 6. With these values the 3-bit cycle field can carry the out-of-range code 7, and CL2.5 or CL3 can push the effective cycle to 7, which reaches the deepest tap of the delay line. The bench varies the time within each period at which a word settles, relative to the sampling edges, so a wrong edge selection shows up as a one-period latency error. It also drives invalid words with non-zero data to expose any leakage.

// File: rtl/ddr_rsync_pkg.sv
`timescale 1ns/1ps
package ddr_rsync_pkg;

    typedef enum logic [1:0] {
        CL_2   = 2'b00,
        CL_25  = 2'b01,
        CL_3   = 2'b10,
        CL_RSV = 2'b11
    } cl_code_e;

    typedef enum logic [1:0] {
        PH_CLK_RISE  = 2'd0,
        PH_WCLK_FALL = 2'd1,
        PH_CLK_FALL  = 2'd2,
        PH_WCLK_RISE = 2'd3
    } phase_e;

endpackage

// File: rtl/rsync_cfg_map.sv
`timescale 1ns/1ps
module rsync_cfg_map
    import ddr_rsync_pkg::*;
#(
    parameter int CYC_MAX = 6,
    parameter int CW      = 3,
    parameter int EW      = 3
) (
    input  logic [CW-1:0] cyc_set,
    input  logic [1:0]    phase_set,
    input  logic [1:0]    cl_code,
    output logic [EW-1:0] eff_cyc,
    output logic [1:0]    eff_ph
);
    localparam int TW = EW + 2;

    logic [EW-1:0] cyc_lim;
    logic [TW-1:0] quarters;

    always_comb begin
        cyc_lim  = (int'(cyc_set) > CYC_MAX) ? EW'(CYC_MAX) : EW'(cyc_set);
        quarters = {cyc_lim, phase_set};
        case (cl_code_e'(cl_code))
            CL_25:   quarters = quarters + TW'(2);
            CL_3:    quarters = quarters + TW'(4);
            default: quarters = quarters;
        endcase
        eff_cyc = quarters[TW-1:2];
        eff_ph  = quarters[1:0];
    end

endmodule

// File: rtl/rsync_edge_capture.sv
`timescale 1ns/1ps
module rsync_edge_capture
    import ddr_rsync_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         wr_clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic [1:0]   sel_ph,
    output logic [W-1:0] xfer_q
);
    logic [W-1:0] q90_q, q180_q, q270_q;
    logic [W-1:0] xfer_d;

    // Quarter-point sample: falling edge of the leading clock
    always_ff @(negedge wr_clk or negedge rst_n) begin
        if (!rst_n) q90_q <= '0;
        else        q90_q <= d_in;
    end

    // Half-point sample: falling edge of the system clock
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q180_q <= '0;
        else        q180_q <= d_in;
    end

    // Three-quarter-point sample: rising edge of the leading clock
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) q270_q <= '0;
        else        q270_q <= d_in;
    end

    always_comb begin
        case (phase_e'(sel_ph))
            PH_CLK_RISE:  xfer_d = d_in;
            PH_WCLK_FALL: xfer_d = q90_q;
            PH_CLK_FALL:  xfer_d = q180_q;
            default:      xfer_d = q270_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) xfer_q <= '0;
        else        xfer_q <= xfer_d;
    end

endmodule

// File: rtl/rsync_delay_line.sv
`timescale 1ns/1ps
module rsync_delay_line #(
    parameter int W     = 9,
    parameter int DEPTH = 7,
    parameter int EW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d_in,
    input  logic [EW-1:0] sel,
    output logic [W-1:0]  tap_out
);
    logic [W-1:0] stg_d [DEPTH];
    logic [W-1:0] stg_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_comb stg_d[g] = d_in;
        end else begin : g_body
            always_comb stg_d[g] = stg_q[g-1];

            a_r4_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
                stg_q[g] == $past(stg_q[g-1]));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    always_comb begin
        if (sel == '0) tap_out = d_in;
        else           tap_out = stg_q[sel - EW'(1)];
    end

endmodule

// File: rtl/ddr_rsync_top.sv
`timescale 1ns/1ps
module ddr_rsync_top
    import ddr_rsync_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CYC_MAX = 6,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cap_data,
    input  logic          cap_valid,
    input  logic [CW-1:0] cyc_set,
    input  logic [1:0]    phase_set,
    input  logic [1:0]    cl_code,
    input  logic          mid_reg_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int W     = DW + 1;
    localparam int DEPTH = CYC_MAX + 1;
    localparam int EW    = $clog2(CYC_MAX + 2);

    typedef struct packed {
        logic [W-1:0] mid;
        logic [W-1:0] out;
    } st_t;

    logic [EW-1:0] eff_cyc;
    logic [1:0]    eff_ph;
    logic [W-1:0]  xfer_q;
    logic [W-1:0]  line_in;
    logic [W-1:0]  line_out;
    st_t           st_d, st_q;

    rsync_cfg_map #(.CYC_MAX(CYC_MAX), .CW(CW), .EW(EW)) cfg_i (
        .cyc_set   (cyc_set),
        .phase_set (phase_set),
        .cl_code   (cl_code),
        .eff_cyc   (eff_cyc),
        .eff_ph    (eff_ph)
    );

    rsync_edge_capture #(.W(W)) cap_i (
        .clk    (clk),
        .wr_clk (wr_clk),
        .rst_n  (rst_n),
        .d_in   ({cap_valid, cap_data}),
        .sel_ph (eff_ph),
        .xfer_q (xfer_q)
    );

    rsync_delay_line #(.W(W), .DEPTH(DEPTH), .EW(EW)) dly_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_in    (line_in),
        .sel     (eff_cyc),
        .tap_out (line_out)
    );

    always_comb begin
        st_d     = st_q;
        st_d.mid = xfer_q;
        line_in  = mid_reg_en ? st_q.mid : xfer_q;
        st_d.out = line_out[W-1] ? line_out : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.out[W-1];
    assign rd_data  = st_q.out[DW-1:0];

    // Setting checks: relate the raw ports to the mapped setting
    logic [EW-1:0] cyc_lim_chk;
    assign cyc_lim_chk = (int'(cyc_set) > CYC_MAX) ? EW'(CYC_MAX) : EW'(cyc_set);

    a_r6_cl2_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_code == CL_2 || cl_code == CL_RSV) |->
            (eff_cyc == cyc_lim_chk && eff_ph == phase_set));

    a_r6_cl3_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_code == CL_3) |->
            (eff_cyc == cyc_lim_chk + EW'(1) && eff_ph == phase_set));

    a_r5_cl25_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_code == CL_25) |->
            ({eff_cyc, eff_ph} == {cyc_lim_chk, phase_set} + (EW+2)'(2)));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

endmodule

// File: tb/ddr_rsync_top_tb_top.sv
`timescale 1ns/1ps
module ddr_rsync_top_tb_top;

    localparam int T = 20;
    localparam int Q = T / 4;

    logic       clk, wr_clk, rst_n;
    logic [7:0] cap_data;
    logic       cap_valid;
    logic [2:0] cyc_set;
    logic [1:0] phase_set, cl_code;
    logic       mid_reg_en;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int         tgt;
        logic       v;
        logic [7:0] d;
        string      tag;
    } exp_t;
    exp_t sb[$];

    ddr_rsync_top dut_i (
        .clk(clk), .wr_clk(wr_clk), .rst_n(rst_n),
        .cap_data(cap_data), .cap_valid(cap_valid),
        .cyc_set(cyc_set), .phase_set(phase_set), .cl_code(cl_code),
        .mid_reg_en(mid_reg_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    initial begin
        clk = 0;
        forever #(T/2) clk = ~clk;
    end

    initial begin
        wr_clk = 0;
        #Q wr_clk = 1;
        forever begin
            #(T/2) wr_clk = 0;
            #(T/2) wr_clk = 1;
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop and compare when the target cycle arrives
    initial forever begin
        @(posedge clk);
        #2;
        while (sb.size() > 0 && sb[0].tgt <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.tgt < cyc) begin
                fails++;
                $display("FAIL %s missed slot tgt=%0d now=%0d", e.tag, e.tgt, cyc);
            end else if (rd_valid !== e.v || rd_data !== e.d) begin
                fails++;
                $display("FAIL %s cyc=%0d actual v=%0b d=%02h expected v=%0b d=%02h",
                         e.tag, cyc, rd_valid, rd_data, e.v, e.d);
            end
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            cap_valid = 0;
            cap_data  = 8'h00;
        end
    endtask

    task automatic run_case(input int cs, input int ph, input int cl, input bit ir,
                            input int off, input int seed, input string tag);
        int tot, ec, ep, base, lat;
        while (sb.size() > 0) @(posedge clk);
        idle(4);
        #3;
        cyc_set    = 3'(cs);
        phase_set  = 2'(ph);
        cl_code    = 2'(cl);
        mid_reg_en = ir;
        idle(14);
        tot  = ((cs > 6) ? 6 : cs) * 4 + ph + ((cl == 1) ? 2 : 0) + ((cl == 2) ? 4 : 0);
        ec   = tot / 4;
        ep   = tot % 4;
        base = (ep == 0) ? 1 : ((off < ep * Q) ? 1 : 2);
        lat  = base + (ir ? 1 : 0) + ec + 1;
        for (int k = 0; k < 9; k++) begin
            exp_t e;
            logic v;
            logic [7:0] d;
            @(posedge clk);
            #(off);
            v = ((k % 3) != 2);
            d = 8'(seed * 16 + k + 1);
            cap_valid = v;
            cap_data  = d;
            e.tgt = cyc + lat;
            e.v   = v;
            e.d   = v ? d : 8'h00;
            e.tag = tag;
            sb.push_back(e);
        end
        @(posedge clk);
        #(off);
        cap_valid = 0;
        cap_data  = 8'h00;
    endtask

    initial begin
        rst_n = 0; cap_valid = 0; cap_data = 0;
        cyc_set = 0; phase_set = 0; cl_code = 0; mid_reg_en = 0;
        #33;
        checks++;
        if (rd_valid !== 1'b0 || rd_data !== 8'h00) begin
            fails++;
            $display("FAIL R1 reset actual v=%0b d=%02h expected v=0 d=00", rd_valid, rd_data);
        end
        #14 rst_n = 1;

        run_case(0, 0, 0, 0, 1,  1, "R2 ph0 base");
        run_case(0, 1, 0, 0, 1,  2, "R3 ph1 early");
        run_case(0, 1, 0, 0, 7,  3, "R3 ph1 late");
        run_case(0, 2, 0, 0, 7,  4, "R3 ph2 early");
        run_case(0, 2, 0, 0, 12, 5, "R3 ph2 late");
        run_case(0, 3, 0, 0, 12, 6, "R3 ph3 early");
        run_case(0, 3, 0, 0, 17, 7, "R3 ph3 late");
        run_case(3, 0, 0, 0, 1,  8, "R4 cyc3");
        run_case(6, 2, 0, 0, 7,  9, "R4 cyc6");
        run_case(7, 0, 0, 0, 1, 10, "R4 cyc7 clamp");
        run_case(2, 1, 1, 0, 7, 11, "R5 cl25 no wrap");
        run_case(1, 3, 1, 0, 7, 12, "R5 cl25 wrap");
        run_case(6, 3, 1, 0, 12, 13, "R5 cl25 deepest");
        run_case(6, 2, 2, 0, 7, 14, "R6 cl3 deepest");
        run_case(2, 1, 3, 0, 1, 15, "R6 code11 as cl2");
        run_case(1, 3, 0, 1, 12, 0, "R7 mid reg");
        run_case(4, 2, 2, 1, 12, 1, "R8 R9 combined");

        while (sb.size() > 0) @(posedge clk);
        idle(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(T * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule